// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator CPU. It takes two 8-bit operands, a carry input and a 3-bit operation code. It produces an 8-bit result and a status byte. The operation set covers addition and subtraction, each with and without carry, a compare, and the bitwise AND, OR and XOR. The result and the status byte are purely combinational.

A status register captures the status byte on a rising clock edge, but only when the caller asserts a write enable. Instructions that must not disturb the condition codes can therefore still use the ALU. One status bit has two meanings. After a bitwise operation it reports even parity of the result. After an arithmetic operation it reports two's-complement overflow. A compare runs the subtraction and produces its flags, but returns the first operand unchanged, so writing the result back to the accumulator leaves it intact.

Top module: `alu8_core`

## Requirements
- R1: Status bit 7 (sign) equals bit 7 of the flag-producing value: the sum or difference for arithmetic and compare, the bitwise value for logic operations.
- R2: Status bit 6 (zero) is 1 exactly when that flag-producing value is 0x00.
- R3: For arithmetic and compare, status bit 4 (half carry) is 1 on a carry out of bit 3 (add codes) or on a borrow into bit 3 (subtract and compare codes).
- R4: For arithmetic and compare, status bit 2 is 1 exactly when the signed two's-complement result lies outside -128..127.
- R5: For AND, OR and XOR, status bit 2 is 1 when the result has an even number of 1 bits, and 0 when odd.
- R6: Status bit 1 (subtract) is 1 for opSel codes 2 (SUB), 3 (SBC) and 4 (CMP), and 0 for all other codes.
- R7: For arithmetic and compare, status bit 0 (carry) is 1 on a carry out of bit 7 for codes 0 and 1, or on a borrow for codes 2, 3 and 4.
- R8: The result equals the 8-bit value of opA+opB (code 0), opA+opB+carryIn (1), opA-opB (2), opA-opB-carryIn (3), opA&opB (5), opA|opB (6) or opA^opB (7).
- R9: Code 4 (CMP) returns result = opA, and its flags are those of opA-opB.
- R10: Status bits 5 and 3 always read as 0.
- R11: Logic codes 5..7 force carry and subtract to 0. They set half carry to 1 for AND (code 5) and to 0 for OR and XOR.
- R12: Reset (rstN low) clears the flag register to 0x00. On a rising clock edge the register loads the status byte when flagWrEn is 1, and holds its value when flagWrEn is 0.
- R13: carryIn affects only codes 1 (ADC) and 3 (SBC). Codes 0 and 2 give the same result whatever carryIn is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 3 | Operation code: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 AND, 6 OR, 7 XOR |
| opA | input | 8 | Accumulator operand (destination) |
| opB | input | 8 | Source operand |
| carryIn | input | 1 | Carry/borrow input, used only by ADC and SBC |
| flagWrEn | input | 1 | Loads the flag register on the next rising edge |
| result | output | 8 | Combinational result |
| flagsNext | output | 8 | Combinational status byte {S,Z,0,H,0,P/V,N,C} |
| flagsReg | output | 8 | Registered status byte |

## Verification
The assertions check on every clock cycle the properties that follow from the ports alone. These are: the two constant-zero status bits, sign and zero against the result for non-compare codes, the subtract bit against the operation code, the cleared carry and subtract bits after logic codes, compare passing opA through, and the load/hold behaviour of the flag register. The arithmetic content cannot be stated as a simple port relation, so only the bench's sweep shows it. That sweep covers every operand pair for every code: carry and borrow at bit 7 and bit 3, signed overflow, parity after logic codes, and the effect of carryIn on ADC and SBC.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_CMP = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_NONE = 2'd0,
    LG_AND  = 2'd1,
    LG_OR   = 2'd2,
    LG_XOR  = 2'd3
  } logicSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic      subMode;   // invert source, borrow sense on carries
    logic      takeCarry; // fold carryIn into the sum
    logic      keepAcc;   // pass opA to the result port
    logicSel_e logicSel;  // bitwise function, LG_NONE for arithmetic
  } aluStrobe_t;

  // Status byte bit positions
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;
  localparam int FLAG_W  = 8;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [2:0] opSel,
  output aluStrobe_t strobe
);

  aluOp_e opCode;
  assign opCode = aluOp_e'(opSel);

  always_comb begin
    strobe = '{subMode: 1'b0, takeCarry: 1'b0, keepAcc: 1'b0, logicSel: LG_NONE};
    case (opCode)
      OP_ADD: ;
      OP_ADC: strobe.takeCarry = 1'b1;
      OP_SUB: strobe.subMode = 1'b1;
      OP_SBC: begin
        strobe.subMode   = 1'b1;
        strobe.takeCarry = 1'b1;
      end
      OP_CMP: begin
        strobe.subMode = 1'b1;
        strobe.keepAcc = 1'b1;
      end
      OP_AND: strobe.logicSel = LG_AND;
      OP_OR:  strobe.logicSel = LG_OR;
      OP_XOR: strobe.logicSel = LG_XOR;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_dpath.sv
module alu8_dpath
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic              carryIn,
  input  aluStrobe_t        strobe,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags
);

  localparam int HB = W / 2;

  logic [W-1:0] srcOp;
  logic         cInEff;
  logic [W:0]   sumFull;
  logic [HB:0]  sumLow;
  logic [W-1:0] arithRes;
  logic [W-1:0] logicRes;
  logic [W-1:0] flagSrc;
  logic         carryOut;
  logic         halfOut;
  logic         ovfOut;
  logic         isLogic;

  // Subtraction as a + ~b + 1 - borrowIn
  assign srcOp   = strobe.subMode ? ~opB : opB;
  assign cInEff  = strobe.subMode ^ (strobe.takeCarry & carryIn);
  assign sumFull = {1'b0, opA} + {1'b0, srcOp} + {{W{1'b0}}, cInEff};
  assign sumLow  = {1'b0, opA[HB-1:0]} + {1'b0, srcOp[HB-1:0]} + {{HB{1'b0}}, cInEff};
  assign arithRes = sumFull[W-1:0];
  assign carryOut = sumFull[W] ^ strobe.subMode;
  assign halfOut  = sumLow[HB] ^ strobe.subMode;
  assign ovfOut   = (opA[W-1] == srcOp[W-1]) && (arithRes[W-1] != opA[W-1]);

  always_comb begin
    case (strobe.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = '0;
    endcase
  end

  assign isLogic = (strobe.logicSel != LG_NONE);
  assign flagSrc = isLogic ? logicRes : arithRes;
  assign result  = strobe.keepAcc ? opA : flagSrc;

  always_comb begin
    flags          = '0;
    flags[FLAG_S]  = flagSrc[W-1];
    flags[FLAG_Z]  = (flagSrc == '0);
    flags[FLAG_H]  = isLogic ? (strobe.logicSel == LG_AND) : halfOut;
    flags[FLAG_PV] = isLogic ? ~^logicRes : ovfOut;
    flags[FLAG_N]  = strobe.subMode;
    flags[FLAG_C]  = isLogic ? 1'b0 : carryOut;
  end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] dIn,
  output logic [FLAG_W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     q <= '0;
    else if (wrEn) q <= dIn;
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opSel,
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic       carryIn,
  input  logic       flagWrEn,
  output logic [7:0] result,
  output logic [7:0] flagsNext,
  output logic [7:0] flagsReg
);

  aluStrobe_t strobe;

  alu8_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu8_dpath #(.W(8)) u_dpath (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .strobe  (strobe),
    .result  (result),
    .flags   (flagsNext)
  );

  alu8_flagreg u_flagreg (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (flagWrEn),
    .dIn  (flagsNext),
    .q    (flagsReg)
  );

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] opSel,
  input logic [7:0] opA,
  input logic       flagWrEn,
  input logic [7:0] result,
  input logic [7:0] flagsNext,
  input logic [7:0] flagsReg
);

  assert_spare_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flagsNext[5] == 1'b0) && (flagsNext[3] == 1'b0));

  assert_sign_R1: assert property (@(posedge clk) disable iff (!rstN)
    (opSel != 3'd4) |-> (flagsNext[7] == result[7]));

  assert_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opSel != 3'd4) |-> (flagsNext[6] == (result == 8'h00)));

  assert_sub_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    flagsNext[1] == (opSel == 3'd2 || opSel == 3'd3 || opSel == 3'd4));

  assert_cmp_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'd4) |-> (result == opA));

  assert_logic_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= 3'd5) |-> (flagsNext[0] == 1'b0 && flagsNext[1] == 1'b0));

  assert_flag_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> (flagsReg == $past(flagsNext)));

  assert_flag_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !flagWrEn |=> $stable(flagsReg));

endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opSel     (opSel),
  .opA       (opA),
  .flagWrEn  (flagWrEn),
  .result    (result),
  .flagsNext (flagsNext),
  .flagsReg  (flagsReg)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opSel = 3'd0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic       carryIn = 1'b0;
  logic       flagWrEn = 1'b0;
  logic [7:0] result;
  logic [7:0] flagsNext;
  logic [7:0] flagsReg;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
    .carryIn(carryIn), .flagWrEn(flagWrEn), .result(result),
    .flagsNext(flagsNext), .flagsReg(flagsReg)
  );

  // Reference model from the requirements, integer arithmetic
  task automatic refModel(input int op, input int a, input int b, input int c,
                          output logic [7:0] expRes, output logic [7:0] expFlg);
    int sa, sb, raw, sraw, cc;
    logic [7:0] val;
    logic fs, fz, fh, fpv, fn, fc;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (op <= 1) begin
      cc = (op == 1) ? c : 0;
      raw = a + b + cc; sraw = sa + sb + cc;
      val = raw[7:0];
      fc = (raw > 255); fh = ((a % 16) + (b % 16) + cc) > 15;
      fpv = (sraw > 127) || (sraw < -128); fn = 1'b0;
    end else if (op <= 4) begin
      cc = (op == 3) ? c : 0;
      raw = a - b - cc; sraw = sa - sb - cc;
      val = raw[7:0];
      fc = (raw < 0); fh = ((a % 16) - (b % 16) - cc) < 0;
      fpv = (sraw > 127) || (sraw < -128); fn = 1'b1;
    end else begin
      if (op == 5) val = a[7:0] & b[7:0];
      else if (op == 6) val = a[7:0] | b[7:0];
      else val = a[7:0] ^ b[7:0];
      fc = 1'b0; fn = 1'b0; fh = (op == 5);
      fpv = ($countones(val) % 2) == 0;
    end
    fs = val[7]; fz = (val == 8'h00);
    expFlg = {fs, fz, 1'b0, fh, 1'b0, fpv, fn, fc};
    expRes = (op == 4) ? a[7:0] : val;
  endtask

  function automatic string tagFor(logic [7:0] diff, int op);
    if (diff[7]) return "R1";
    if (diff[6]) return "R2";
    if (diff[4]) return (op >= 5) ? "R11" : "R3";
    if (diff[2]) return (op >= 5) ? "R5" : "R4";
    if (diff[1]) return "R6";
    if (diff[0]) return (op >= 5) ? "R11" : "R7";
    return "R10";
  endfunction

  task automatic checkVal(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  initial begin : main
    logic [7:0] eRes, eFlg;
    #20;
    checkVal("R12 reset value", flagsReg, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // Sweep: every code, every operand pair; carryIn alternates with the pair
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          opSel = op[2:0]; opA = a[7:0]; opB = b[7:0];
          carryIn = a[0] ^ b[0] ^ op[0];
          #1;
          refModel(op, a, b, int'(carryIn), eRes, eFlg);
          testCount++;
          if (result !== eRes) begin
            failCount++;
            $display("FAIL %s: op %0d a %02h b %02h c %0d result actual %02h expected %02h",
                     (op == 4) ? "R9" : "R8", op, a, b, carryIn, result, eRes);
          end else if (flagsNext !== eFlg) begin
            failCount++;
            $display("FAIL %s: op %0d a %02h b %02h c %0d flags actual %02h expected %02h",
                     tagFor(flagsNext ^ eFlg, op), op, a, b, carryIn, flagsNext, eFlg);
          end
        end
      end
    end

    // R13: carryIn matters only for ADC and SBC
    @(negedge clk);
    opA = 8'h05; opB = 8'h02; carryIn = 1'b1;
    opSel = 3'd0; #1; checkVal("R13 ADD ignores carryIn", result, 8'h07);
    opSel = 3'd2; #1; checkVal("R13 SUB ignores carryIn", result, 8'h03);
    opSel = 3'd1; #1; checkVal("R13 ADC uses carryIn", result, 8'h08);
    opSel = 3'd3; #1; checkVal("R13 SBC uses carryIn", result, 8'h02);

    // R12: flag register load and hold
    @(negedge clk);
    opSel = 3'd2; opA = 8'h00; opB = 8'h01; carryIn = 1'b0; flagWrEn = 1'b1;
    @(negedge clk);
    checkVal("R12 load on enable", flagsReg, 8'h93);
    opSel = 3'd5; opA = 8'h00; opB = 8'h00; flagWrEn = 1'b0;
    @(negedge clk);
    checkVal("R12 hold when disabled", flagsReg, 8'h93);
    flagWrEn = 1'b1;
    @(negedge clk);
    checkVal("R12 reload AND flags", flagsReg, 8'h54);
    flagWrEn = 1'b0;
    @(negedge clk);
    rstN = 1'b0; #1;
    checkVal("R12 async reset clears", flagsReg, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule